// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block supervises software by counting down from a programmed time-out value. A prescaler divides the clock and feeds a down-counter. Software must write the restart register often enough to keep the counter from reaching the end of its count. If the count does run out, the block sends a one-cycle reset request to the chip's reset generator. The counter then reloads and starts counting again.

Two features help when the CPU is halted in debug. With the pause bit set, the debug input freezes both counters. Without the pause bit, a time-out in debug mode sends no reset request. It sets an interrupt flag instead, and only if interrupts are enabled. A guard protects the control register: software must first write a fixed key to an unlock address. The unlock then covers only the next bus write.

This is a single-clock model. The counters and the register file share one clock. The register port is a plain word-wide bus. A read returns its data one cycle after the read strobe.

Top module: `wdt_key_guard`

## Requirements
- R1: After reset, `rst_req_o` and `irq_o` are low, CTRL (address 0) reads 0, and COUNT (address 7) reads the parameter TIMEOUT_RST.
- R2: Take a programmed time-out C (TIMEOUT, address 2) and a prescale P (PRESCALE, address 3). The enable bit is CTRL bit 0. When the counter is enabled or restarted, `rst_req_o` rises (C+1)*(P+1) clock edges later.
- R3: Each time-out raises `rst_req_o` for exactly one cycle whenever (C+1)*(P+1) > 1. The counter reloads and times out again every (C+1)*(P+1) cycles.
- R4: Any write to RESTART (address 4) reloads the counter with C and clears the prescaler, so restarts issued sooner than one period prevent any reset request.
- R5: A write to CTRL takes effect only if the write just before it put the key 0x5AC3_3CA5 into UNLOCK (address 1). Any other write removes the unlock, and a rejected CTRL write leaves CTRL unchanged.
- R6: While `dbg_i` is high and the pause bit (CTRL bit 1) is set, the prescaler and counter hold their values and no time-out occurs. Counting resumes from the held value once `dbg_i` falls.
- R7: A time-out while `dbg_i` is high never asserts `rst_req_o`. It sets the interrupt flag `irq_o` (also read as STATUS bit 0, address 8) when IRQ_EN (address 5) bit 0 is set.
- R8: With IRQ_EN bit 0 clear, a time-out in debug mode leaves `irq_o` low.
- R9: Any write to IRQ_CLR (address 6) clears `irq_o` in the cycle that follows, unless a debug time-out occurs in that same cycle.
- R10: While CTRL bit 0 is clear, the counter stays loaded with C and no reset request or interrupt is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (always-on domain) |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Register address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, valid the cycle after `rd_en` |
| dbg_i | input | 1 | CPU halted in debug |
| rst_req_o | output | 1 | One-cycle reset request to the reset generator |
| irq_o | output | 1 | Debug-mode time-out interrupt flag |

## Verification
The bench runs every combination of time-out and prescale from 0 to 3 and measures the edge count up to the first and the second reset request. If the design were off by one in either divider, the count would shift by one or by a multiple of P+1. If it failed to reload, the second period would be wrong. Key handling is tested four ways: no unlock, a wrong key, an unlock used up by some other write, and a correct unlock. A guard that remembered the unlock would accept a stale key. The debug tests confirm three things: pause freezes COUNT, debug turns resets into interrupts only when interrupts are enabled, and the clear register drops the flag. A design that gave reset priority over debug would send a reset request while the CPU sits halted.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam logic [3:0] A_CTRL     = 4'd0;
  localparam logic [3:0] A_UNLOCK   = 4'd1;
  localparam logic [3:0] A_TIMEOUT  = 4'd2;
  localparam logic [3:0] A_PRESCALE = 4'd3;
  localparam logic [3:0] A_RESTART  = 4'd4;
  localparam logic [3:0] A_IRQEN    = 4'd5;
  localparam logic [3:0] A_IRQCLR   = 4'd6;
  localparam logic [3:0] A_COUNT    = 4'd7;
  localparam logic [3:0] A_STATUS   = 4'd8;

  localparam logic [31:0] UNLOCK_KEY = 32'h5AC3_3CA5;

  typedef struct packed {
    logic pause;
    logic run;
  } wdt_ctrl_t;
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter int CNT_W = 32,
  parameter int PRE_W = 32,
  parameter logic [CNT_W-1:0] TIMEOUT_RST = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              irq_i,
  output logic [DATA_W-1:0] rdata,
  output wdt_ctrl_t         ctrl_o,
  output logic [CNT_W-1:0]  tmo_o,
  output logic [PRE_W-1:0]  pre_lim_o,
  output logic              irq_en_o,
  output logic              restart_o,
  output logic              irq_clr_o
);
  localparam int CTRL_W = $bits(wdt_ctrl_t);

  logic unlocked_q;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [3:0] r);
    return a == ADDR_W'(r);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      unlocked_q <= 1'b0;
      ctrl_o     <= '0;
      tmo_o      <= TIMEOUT_RST;
      pre_lim_o  <= '0;
      irq_en_o   <= 1'b0;
    end else if (wr_en) begin
      unlocked_q <= hit(addr, A_UNLOCK) && (wdata == DATA_W'(UNLOCK_KEY));
      if (hit(addr, A_CTRL) && unlocked_q) ctrl_o <= wdt_ctrl_t'(wdata[CTRL_W-1:0]);
      if (hit(addr, A_TIMEOUT))  tmo_o     <= wdata[CNT_W-1:0];
      if (hit(addr, A_PRESCALE)) pre_lim_o <= wdata[PRE_W-1:0];
      if (hit(addr, A_IRQEN))    irq_en_o  <= wdata[0];
    end
  end

  always_comb begin
    restart_o = wr_en && hit(addr, A_RESTART);
    irq_clr_o = wr_en && hit(addr, A_IRQCLR);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      rdata <= '0;
      if (hit(addr, A_CTRL))     rdata <= DATA_W'(ctrl_o);
      if (hit(addr, A_TIMEOUT))  rdata <= DATA_W'(tmo_o);
      if (hit(addr, A_PRESCALE)) rdata <= DATA_W'(pre_lim_o);
      if (hit(addr, A_IRQEN))    rdata <= DATA_W'(irq_en_o);
      if (hit(addr, A_COUNT))    rdata <= DATA_W'(cnt_i);
      if (hit(addr, A_STATUS))   rdata <= DATA_W'(irq_i);
    end
  end
endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int PRE_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear_i,
  input  logic             hold_i,
  input  logic [PRE_W-1:0] limit_i,
  output logic             tick_o
);
  logic [PRE_W-1:0] pre_q;

  assign tick_o = !clear_i && !hold_i && (pre_q == limit_i);

  always_ff @(posedge clk) begin
    if (rst || clear_i) pre_q <= '0;
    else if (!hold_i)   pre_q <= (pre_q == limit_i) ? '0 : pre_q + 1'b1;
  end
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int CNT_W = 32,
  parameter logic [CNT_W-1:0] TIMEOUT_RST = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expire_o
);
  assign expire_o = !load_i && tick_i && (cnt_o == '0);

  always_ff @(posedge clk) begin
    if (rst)         cnt_o <= TIMEOUT_RST;
    else if (load_i) cnt_o <= reload_i;
    else if (tick_i) cnt_o <= (cnt_o == '0) ? reload_i : cnt_o - 1'b1;
  end
endmodule

// File: rtl/wdt_key_guard.sv
module wdt_key_guard
  import wdt_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter int CNT_W = 32,
  parameter int PRE_W = 32,
  parameter logic [CNT_W-1:0] TIMEOUT_RST = CNT_W'(32'h0000_FFFF)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              dbg_i,
  output logic              rst_req_o,
  output logic              irq_o
);
  wdt_ctrl_t        ctrl;
  logic [CNT_W-1:0] tmo, cnt;
  logic [PRE_W-1:0] pre_lim;
  logic             irq_en, restart, irq_clr, tick, expire, hold, reload;
  logic             ctrl_run, ctrl_pause;

  assign ctrl_run   = ctrl.run;
  assign ctrl_pause = ctrl.pause;
  assign hold       = !ctrl_run || (dbg_i && ctrl_pause);
  assign reload     = restart || !ctrl_run;

  wdt_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .PRE_W(PRE_W),
    .TIMEOUT_RST(TIMEOUT_RST)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .cnt_i(cnt), .irq_i(irq_o), .rdata(rdata),
    .ctrl_o(ctrl), .tmo_o(tmo), .pre_lim_o(pre_lim), .irq_en_o(irq_en),
    .restart_o(restart), .irq_clr_o(irq_clr)
  );

  wdt_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst(rst), .clear_i(reload), .hold_i(hold),
    .limit_i(pre_lim), .tick_o(tick)
  );

  wdt_counter #(.CNT_W(CNT_W), .TIMEOUT_RST(TIMEOUT_RST)) u_cnt (
    .clk(clk), .rst(rst), .load_i(reload), .tick_i(tick),
    .reload_i(tmo), .cnt_o(cnt), .expire_o(expire)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rst_req_o <= 1'b0;
      irq_o     <= 1'b0;
    end else begin
      rst_req_o <= expire && !dbg_i;
      if (expire && dbg_i && irq_en) irq_o <= 1'b1;
      else if (irq_clr)              irq_o <= 1'b0;
    end
  end
endmodule

// File: rtl/wdt_key_guard_chk.sv
module wdt_key_guard_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic             irq_clr,
  input logic             dbg_i,
  input logic             ctrl_run,
  input logic             ctrl_pause,
  input logic [CNT_W-1:0] cnt,
  input logic             rst_req_o,
  input logic             irq_o
);
  // R7
  no_reset_in_debug_chk: assert property (@(posedge clk) disable iff (rst)
    rst_req_o |-> !$past(dbg_i));
  // R7
  irq_only_from_debug_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_o) |-> $past(dbg_i));
  // R6
  pause_freezes_count_chk: assert property (@(posedge clk) disable iff (rst)
    (dbg_i && ctrl_pause && ctrl_run && !wr_en) |=> $stable(cnt));
  // R9
  irq_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_clr && !dbg_i) |=> !irq_o);
  // R10
  idle_no_reset_chk: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_run && !wr_en) |=> !rst_req_o);
endmodule

bind wdt_key_guard wdt_key_guard_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .irq_clr(irq_clr), .dbg_i(dbg_i),
  .ctrl_run(ctrl_run), .ctrl_pause(ctrl_pause), .cnt(cnt),
  .rst_req_o(rst_req_o), .irq_o(irq_o)
);

// File: tb/wdt_key_guard_test.sv
module wdt_key_guard_test;
  localparam logic [31:0] KEY = 32'h5AC3_3CA5;
  localparam int TRST = 32'h0000_FFFF;

  logic clk = 1'b0, rst = 1'b1, wr_en = 1'b0, rd_en = 1'b0, dbg = 1'b0;
  logic [3:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic rst_req, irq;
  int checks = 0, errors = 0, cycles = 0;
  logic done = 1'b0;

  wdt_key_guard uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .dbg_i(dbg), .rst_req_o(rst_req), .irq_o(irq)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cycles <= cycles + 1;

  initial begin
    wait (cycles > 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired act=%0d exp=<100000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic set_ctrl(input logic [31:0] v);
    wr(4'd1, KEY); wr(4'd0, v);
  endtask

  // count edges until rst_req seen, bounded
  task automatic wait_rst(output int n);
    n = 0;
    do begin
      @(posedge clk); n++;
      @(negedge clk);
    end while (!rst_req && n < 200);
  endtask

  // watch n cycles, return number of cycles rst_req / irq high
  task automatic watch(input int n, output int r, output int q);
    r = 0; q = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk); r += int'(rst_req); q += int'(irq);
    end
  endtask

  initial begin
    logic [31:0] d, d2;
    int n, m, r, q;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 rst_req", rst_req, 0);
    chk("R1 irq", irq, 0);
    rd(4'd0, d); chk("R1 ctrl", d, 0);
    rd(4'd7, d); chk("R1 count", d, TRST);

    // R5 key guard
    wr(4'd0, 32'd3); rd(4'd0, d); chk("R5 no unlock", d, 0);
    wr(4'd1, KEY ^ 32'h1); wr(4'd0, 32'd3); rd(4'd0, d); chk("R5 wrong key", d, 0);
    wr(4'd1, KEY); wr(4'd5, 32'd0); wr(4'd0, 32'd3); rd(4'd0, d); chk("R5 unlock consumed", d, 0);
    set_ctrl(32'd2); rd(4'd0, d); chk("R5 good key", d, 2);
    set_ctrl(32'd0);

    // R2/R3 sweep of time-out and prescale
    for (int c = 0; c < 4; c++) begin
      for (int p = 0; p < 4; p++) begin
        set_ctrl(32'd0);
        wr(4'd2, c); wr(4'd3, p);
        // R10 disabled: loaded, no request
        if (c == 3 && p == 3) begin
          watch(20, r, q); chk("R10 no req when off", r, 0);
          rd(4'd7, d); chk("R10 count loaded", d, c);
        end
        set_ctrl(32'd1);
        wait_rst(n); chk($sformatf("R2 period c%0d p%0d", c, p), n, (c + 1) * (p + 1));
        m = 0;
        do begin
          @(posedge clk); m++; @(negedge clk);
          if (m == 1 && (c + 1) * (p + 1) > 1) chk("R3 pulse width", rst_req, 0);
        end while (!rst_req && m < 200);
        chk($sformatf("R3 reload c%0d p%0d", c, p), m, (c + 1) * (p + 1));
      end
    end

    // R4 periodic restart prevents reset (period 8)
    set_ctrl(32'd0); wr(4'd2, 32'd3); wr(4'd3, 32'd1); set_ctrl(32'd1);
    r = 0;
    for (int k = 0; k < 6; k++) begin
      watch(4, m, q); r += m; wr(4'd4, 32'd0);
    end
    chk("R4 no reset with restarts", r, 0);
    wait_rst(n); chk("R4 period after restart", n, 8);

    // R6 pause in debug
    set_ctrl(32'd0); wr(4'd2, 32'd5); wr(4'd3, 32'd0);
    dbg = 1'b1; set_ctrl(32'd3);
    rd(4'd7, d); watch(20, r, q); rd(4'd7, d2);
    chk("R6 count held", d, 5); chk("R6 count stable", d2, 5); chk("R6 no req", r, 0);
    dbg = 1'b0; wait_rst(n); chk("R6 resume", n, 6);

    // R8 debug, irq disabled
    set_ctrl(32'd0); wr(4'd2, 32'd2); wr(4'd5, 32'd0);
    dbg = 1'b1; set_ctrl(32'd1);
    watch(12, r, q); chk("R8 no irq", q, 0); chk("R8 no req", r, 0);

    // R7 debug, irq enabled
    wr(4'd5, 32'd1); watch(12, r, q);
    chk("R7 no req in debug", r, 0); chk("R7 irq set", irq, 1);
    rd(4'd8, d); chk("R7 status", d, 1);

    // R9 clear
    set_ctrl(32'd0); dbg = 1'b0;
    wr(4'd6, 32'd0); chk("R9 irq cleared", irq, 0);
    rd(4'd8, d); chk("R9 status cleared", d, 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule